// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This controller sits between a host request port and a 64K x 16 DRAM with extended data output. The host hands over word or byte transfers with a valid/ready handshake. Each transfer carries a 16-bit word address, two byte enables and write data. The controller turns each transfer into row-strobe, column-strobe, write-enable and output-enable sequences on an 8-bit multiplexed address bus. Read data returns on a one-cycle valid pulse, in request order.

A row stays open after its first access. Later requests to the same row use column-strobe cycles only. A request to another row, or a pending refresh request, closes the row and waits out a precharge period. Read data is sampled after the column strobe has already returned high. This relies on the extended output hold, which keeps the data valid until the next column-strobe fall, so the next page cycle can follow closely. Writes use the early-write form: the write strobes and the data bus are set up a cycle before the column strobe falls.

All strobe timing is counted in controller clocks: `T_RCD` (row strobe to column strobe), `T_CAS` (column strobe low width), `T_CP` (column strobe high time) and `T_RP` (precharge).

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held and directly after it, `dram_ras_n`, `dram_cas_n`, both bits of `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` and `rd_valid` are 0, and `req_ready` is 1 when `ref_req` is 0.
- R2: When `dram_ras_n` falls, `dram_addr` carries address bits [15:8] (row). When `dram_cas_n` falls, `dram_addr` carries bits [7:0] (column). `dram_cas_n` is never low while `dram_ras_n` is high.
- R3: In a write, `dram_we_n[0]` (lower byte, data bits 7:0) is low only if `req_be[0]` was 1. `dram_we_n[1]` (upper byte, bits 15:8) is low only if `req_be[1]` was 1. A byte that is not enabled keeps its old contents.
- R4: A read keeps both `dram_we_n` bits at 1 and holds `dram_oe_n` low while the column strobe is low. It returns the full 16-bit word on `rd_data` with a one-cycle `rd_valid` pulse. The data is sampled at the end of the first cycle after the column strobe rises.
- R5: A request to the row that is already open is served without a new row-strobe fall. Only a column-strobe cycle is issued.
- R6: A request to a different row raises `dram_ras_n`. It stays high for at least `T_RP` cycles before the next row activation.
- R7: While `ref_req` is 1, the open row is closed after the current access. `req_ready` stays 0. `ref_gnt` is 1 only when both strobes are high and precharge is complete.
- R8: `dram_cas_n` stays low for exactly `T_CAS` cycles. It falls at least `T_RCD` cycles after `dram_ras_n` falls.
- R9: In a write, the enabled `dram_we_n` bits are low and `dram_dq_oe` is 1 for at least one cycle before `dram_cas_n` falls. `dram_oe_n` stays 1 throughout.
- R10: `dram_dq_oe` rises only after `dram_oe_n` has been 1 for at least one full cycle.
- R11: Reads complete in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address, bits [15:8] row, [7:0] column |
| req_be | input | 2 | Byte enables: bit 0 lower byte, bit 1 upper byte (writes) |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with returned read word |
| rd_data | output | 16 | Returned read word |
| ref_req | input | 1 | Refresh pending: close the row and stay idle |
| ref_gnt | output | 1 | DRAM idle and precharged while refresh is pending |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 2 | Byte write strobes, active low (bit 0 lower byte) |
| dram_oe_n | output | 1 | DRAM output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data returned from the DRAM |

## Verification
The in-design checks assume that `T_RCD`, `T_CAS`, `T_CP` and `T_RP` are all at least 1. They also assume that host inputs hold steady from the falling edge, where they are driven, to the rising edge that samples them. The bench drives every request on a falling edge and keeps it until the handshake completes. It uses only byte-enable values 01, 10 and 11 for writes, so every write strobes at least one lane. Each read targets either a word written earlier or a word whose value the DRAM model and the bench both treat as zero. The bench drops `ref_req` only after withdrawing any pending request, so no transfer is accepted twice.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RCD  = 3'd1,
    ST_WSET = 3'd2,
    ST_CAS  = 3'd3,
    ST_OPEN = 3'd4,
    ST_PRE  = 3'd5
  } edo_state_e;

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] open_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             hit
);

  logic [ROW_W-1:0] row_q, row_d;
  logic             valid_q, valid_d;

  always_comb begin
    row_d   = row_q;
    valid_d = valid_q;
    if (close_en) begin
      valid_d = 1'b0;
    end else if (open_en) begin
      valid_d = 1'b1;
      row_d   = open_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      row_q   <= row_d;
      valid_q <= valid_d;
    end
  end

  assign hit = valid_q && (row_q == cmp_row);

  AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_en && close_en)); // R6

  AST_CLOSE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |-> valid_q); // R6

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int CNT_W  = 2,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_CP   = 1,
  parameter int T_RP   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [LANES-1:0]       req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  input  logic                   row_hit,
  output logic                   row_open,
  output logic                   row_close,
  input  logic                   tmr_done,
  output logic                   tmr_load,
  output logic [CNT_W-1:0]       tmr_val,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic [LANES-1:0]       dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int MON_W  = CNT_W + 2;
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] L_CP  = CNT_W'(T_CP - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);

  edo_state_e        state_q, state_d;
  logic              ras_n_q, ras_n_d;
  logic              cas_n_q, cas_n_d;
  logic [LANES-1:0]  we_n_q, we_n_d;
  logic              oe_n_q, oe_n_d;
  logic [PIN_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0] dq_out_q, dq_out_d;
  logic              dq_oe_q, dq_oe_d;
  logic              cur_wr_q, cur_wr_d;
  logic [COL_W-1:0]  cur_col_q, cur_col_d;
  logic [LANES-1:0]  cur_be_q, cur_be_d;
  logic [DATA_W-1:0] cur_wd_q, cur_wd_d;
  logic              rd_cap_q, rd_cap_d;
  logic              rd_valid_q, rd_valid_d;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;

  logic             accept;
  logic [ROW_W-1:0] in_row;
  logic [COL_W-1:0] in_col;

  assign in_row = req_addr[ADDR_W-1:COL_W];
  assign in_col = req_addr[COL_W-1:0];

  always_comb begin
    req_ready = 1'b0;
    if (state_q == ST_IDLE) begin
      req_ready = !ref_req;
    end else if (state_q == ST_OPEN) begin
      req_ready = tmr_done && !ref_req && row_hit && (!req_write || oe_n_q);
    end
  end

  assign accept  = req_valid && req_ready;
  assign ref_gnt = (state_q == ST_IDLE) && ref_req;

  always_comb begin
    state_d    = state_q;
    ras_n_d    = ras_n_q;
    cas_n_d    = cas_n_q;
    we_n_d     = we_n_q;
    oe_n_d     = oe_n_q;
    addr_d     = addr_q;
    dq_out_d   = dq_out_q;
    dq_oe_d    = dq_oe_q;
    cur_wr_d   = cur_wr_q;
    cur_col_d  = cur_col_q;
    cur_be_d   = cur_be_q;
    cur_wd_d   = cur_wd_q;
    rd_cap_d   = 1'b0;
    rd_valid_d = rd_cap_q;
    rd_data_d  = rd_cap_q ? dram_dq_in : rd_data_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    row_open   = 1'b0;
    row_close  = 1'b0;

    if (accept) begin
      cur_wr_d  = req_write;
      cur_col_d = in_col;
      cur_be_d  = req_be;
      cur_wd_d  = req_wdata;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          row_open = 1'b1;
          ras_n_d  = 1'b0;
          addr_d   = PIN_W'(in_row);
          tmr_load = 1'b1;
          tmr_val  = L_RCD;
          state_d  = ST_RCD;
        end
      end
      ST_RCD: begin
        if (tmr_done) begin
          addr_d = PIN_W'(cur_col_q);
          if (cur_wr_q) begin
            we_n_d   = ~cur_be_q;
            dq_out_d = cur_wd_q;
            dq_oe_d  = 1'b1;
            state_d  = ST_WSET;
          end else begin
            cas_n_d  = 1'b0;
            oe_n_d   = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = L_CAS;
            state_d  = ST_CAS;
          end
        end
      end
      ST_WSET: begin
        cas_n_d  = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = L_CAS;
        state_d  = ST_CAS;
      end
      ST_CAS: begin
        if (tmr_done) begin
          cas_n_d  = 1'b1;
          we_n_d   = '1;
          dq_oe_d  = 1'b0;
          rd_cap_d = !cur_wr_q;
          tmr_load = 1'b1;
          tmr_val  = L_CP;
          state_d  = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (rd_cap_q) begin
          oe_n_d = 1'b1;
        end
        if (tmr_done) begin
          if (accept) begin
            addr_d = PIN_W'(in_col);
            if (req_write) begin
              we_n_d   = ~req_be;
              dq_out_d = req_wdata;
              dq_oe_d  = 1'b1;
              state_d  = ST_WSET;
            end else begin
              cas_n_d  = 1'b0;
              oe_n_d   = 1'b0;
              tmr_load = 1'b1;
              tmr_val  = L_CAS;
              state_d  = ST_CAS;
            end
          end else if (ref_req || (req_valid && !row_hit)) begin
            ras_n_d   = 1'b1;
            row_close = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = L_RP;
            state_d   = ST_PRE;
          end
        end
      end
      ST_PRE: begin
        if (tmr_done) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ras_n_q    <= 1'b1;
      cas_n_q    <= 1'b1;
      we_n_q     <= '1;
      oe_n_q     <= 1'b1;
      addr_q     <= '0;
      dq_out_q   <= '0;
      dq_oe_q    <= 1'b0;
      cur_wr_q   <= 1'b0;
      cur_col_q  <= '0;
      cur_be_q   <= '0;
      cur_wd_q   <= '0;
      rd_cap_q   <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state_q    <= state_d;
      ras_n_q    <= ras_n_d;
      cas_n_q    <= cas_n_d;
      we_n_q     <= we_n_d;
      oe_n_q     <= oe_n_d;
      addr_q     <= addr_d;
      dq_out_q   <= dq_out_d;
      dq_oe_q    <= dq_oe_d;
      cur_wr_q   <= cur_wr_d;
      cur_col_q  <= cur_col_d;
      cur_be_q   <= cur_be_d;
      cur_wd_q   <= cur_wd_d;
      rd_cap_q   <= rd_cap_d;
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
    end
  end

  assign dram_addr   = addr_q;
  assign dram_ras_n  = ras_n_q;
  assign dram_cas_n  = cas_n_q;
  assign dram_we_n   = we_n_q;
  assign dram_oe_n   = oe_n_q;
  assign dram_dq_out = dq_out_q;
  assign dram_dq_oe  = dq_oe_q;
  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;

  // Strobe-width monitors feeding the timing assertions below
  logic [MON_W-1:0] ras_hi_q, cas_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_hi_q <= MON_W'(T_RP);
      cas_lo_q <= '0;
    end else begin
      if (!ras_n_q) begin
        ras_hi_q <= '0;
      end else if (ras_hi_q != '1) begin
        ras_hi_q <= ras_hi_q + 1'b1;
      end
      if (cas_n_q) begin
        cas_lo_q <= '0;
      end else if (cas_lo_q != '1) begin
        cas_lo_q <= cas_lo_q + 1'b1;
      end
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_q |-> !ras_n_q); // R2

  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> (&we_n_q)); // R4

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_q) |-> (ras_hi_q >= MON_W'(T_RP))); // R6

  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n_q) |-> (cas_lo_q == MON_W'(T_CAS))); // R8

  AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n_q) && !(&we_n_q)) |-> (!(&$past(we_n_q)) && $past(dq_oe_q) && oe_n_q)); // R9

  AST_OE_OFF_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe_q) |-> ($past(oe_n_q) && oe_n_q)); // R10

  AST_REF_GNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n_q && cas_n_q && !req_ready)); // R7

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_CP   = 1,
  parameter int T_RP   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W/8-1:0]    req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic [DATA_W/8-1:0]    dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);

  localparam int LANES  = DATA_W / 8;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int T_M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_M2   = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int TMAX   = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int CNT_W  = (TMAX > 1) ? $clog2(TMAX) : 1;

  logic             row_hit, row_open, row_close;
  logic             tmr_done, tmr_load;
  logic [CNT_W-1:0] tmr_val;

  edo_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  edo_row_tracker #(.ROW_W(ROW_W)) rows_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_en  (row_open),
    .close_en (row_close),
    .open_row (req_addr[ADDR_W-1:COL_W]),
    .cmp_row  (req_addr[ADDR_W-1:COL_W]),
    .hit      (row_hit)
  );

  edo_seq #(
    .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W), .LANES (LANES),
    .CNT_W (CNT_W), .T_RCD (T_RCD), .T_CAS (T_CAS), .T_CP (T_CP), .T_RP (T_RP)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_wdata   (req_wdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .ref_req     (ref_req),
    .ref_gnt     (ref_gnt),
    .row_hit     (row_hit),
    .row_open    (row_open),
    .row_close   (row_close),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_out (dram_dq_out),
    .dram_dq_oe  (dram_dq_oe),
    .dram_dq_in  (dram_dq_in)
  );

endmodule

// File: tb/edo_page_ctrl_tb_top.sv
module edo_page_ctrl_tb_top;

  localparam int T_RCD = 2;
  localparam int T_CAS = 2;
  localparam int T_CP  = 1;
  localparam int T_RP  = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        ref_req;
  logic        ref_gnt;
  logic [7:0]  dram_addr;
  logic        dram_ras_n;
  logic        dram_cas_n;
  logic [1:0]  dram_we_n;
  logic        dram_oe_n;
  logic [15:0] dram_dq_out;
  logic        dram_dq_oe;
  logic [15:0] dram_dq_in;

  edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_be (req_be), .req_wdata (req_wdata),
    .rd_valid (rd_valid), .rd_data (rd_data),
    .ref_req (ref_req), .ref_gnt (ref_gnt),
    .dram_addr (dram_addr), .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n),
    .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
    .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe), .dram_dq_in (dram_dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done_run = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // Bench reference memory and scoreboard queue
  logic [15:0] ref_mem [logic [15:0]];
  logic [15:0] exp_q [$];

  function automatic logic [15:0] ref_rd(input logic [15:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  // Current transfer as seen by the monitor
  logic [15:0] last_addr;
  logic        last_wr;
  logic [1:0]  last_be;

  // DRAM behavioural model plus strobe monitor
  logic [15:0] dmem [logic [15:0]];
  logic [7:0]  m_row, m_col;
  logic [15:0] dq_hold;
  logic        p_ras, p_cas, p_oe, p_dqoe;
  logic [1:0]  p_we;
  int          ras_falls, ras_hi, rcd_cnt, cas_lo;

  assign dram_dq_in = dq_hold;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1'b1; p_cas = 1'b1; p_oe = 1'b1; p_dqoe = 1'b0; p_we = 2'b11;
      ras_falls = 0; ras_hi = 100; rcd_cnt = 0; cas_lo = 0;
      dq_hold = 16'hxxxx;
    end else begin
      // Read return, popped against the scoreboard (R11, R4)
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected read return", {16'h0, rd_data}, 32'h0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rd_data === e, "R4/R11", "read word", {16'h0, rd_data}, {16'h0, e});
        end
      end
      // Row strobe fall
      if (p_ras && !dram_ras_n) begin
        ras_falls++;
        m_row = dram_addr;
        check(dram_addr === last_addr[15:8], "R2", "row on RAS fall", {24'h0, dram_addr}, {24'h0, last_addr[15:8]});
        check(ras_hi >= T_RP, "R6", "precharge cycles", ras_hi, T_RP);
        rcd_cnt = 1;
      end else if (!dram_ras_n && dram_cas_n) begin
        rcd_cnt++;
      end
      if (!dram_cas_n) begin
        check(!dram_ras_n, "R2", "CAS low under RAS", {31'h0, dram_ras_n}, 32'h0);
      end
      // Column strobe fall
      if (p_cas && !dram_cas_n) begin
        m_col = dram_addr;
        check(dram_addr === last_addr[7:0], "R2", "column on CAS fall", {24'h0, dram_addr}, {24'h0, last_addr[7:0]});
        check(rcd_cnt >= T_RCD, "R8", "RAS to CAS cycles", rcd_cnt, T_RCD);
        if (last_wr) begin
          check(dram_we_n === ~last_be, "R3", "byte strobes", {30'h0, dram_we_n}, {30'h0, ~last_be});
          check(p_we === ~last_be && p_dqoe, "R9", "early WE and data", {29'h0, p_dqoe, p_we}, {29'h0, 1'b1, ~last_be});
          check(dram_oe_n === 1'b1, "R9", "OE high on write", {31'h0, dram_oe_n}, 32'h1);
          if (!dram_we_n[0]) dmem[{m_row, m_col}] = {ref_dm(m_row, m_col)[15:8], dram_dq_out[7:0]};
          if (!dram_we_n[1]) dmem[{m_row, m_col}] = {dram_dq_out[15:8], ref_dm(m_row, m_col)[7:0]};
        end else begin
          check(dram_we_n === 2'b11 && dram_oe_n === 1'b0, "R4", "read strobes",
                {29'h0, dram_oe_n, dram_we_n}, {29'h0, 1'b0, 2'b11});
          dq_hold = ref_dm(m_row, m_col);
        end
      end
      // Column strobe rise
      if (!p_cas && dram_cas_n) begin
        check(cas_lo == T_CAS, "R8", "CAS low width", cas_lo, T_CAS);
      end
      if (!p_dqoe && dram_dq_oe) begin
        check(p_oe === 1'b1 && dram_oe_n === 1'b1, "R10", "OE off before drive", {31'h0, p_oe}, 32'h1);
      end
      if (dram_ras_n && dram_cas_n) dq_hold = 16'hxxxx;
      cas_lo = dram_cas_n ? 0 : cas_lo + 1;
      ras_hi = dram_ras_n ? ras_hi + 1 : 0;
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_oe = dram_oe_n;
      p_dqoe = dram_dq_oe; p_we = dram_we_n;
    end
  end

  function automatic logic [15:0] ref_dm(input logic [7:0] r, input logic [7:0] c);
    return dmem.exists({r, c}) ? dmem[{r, c}] : 16'h0000;
  endfunction

  // Driver: one request, pushes expected read data
  task automatic issue(input logic wr, input logic [15:0] a, input logic [1:0] be,
                       input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #0.5;
    last_addr = a; last_wr = wr; last_be = be;
    req_valid = 1'b0;
    if (wr) begin
      logic [15:0] old;
      old = ref_rd(a);
      if (be[0]) old[7:0]  = wd[7:0];
      if (be[1]) old[15:8] = wd[15:8];
      ref_mem[a] = old;
    end else begin
      exp_q.push_back(ref_rd(a));
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "run did not finish", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int falls0;
    logic [15:0] lfsr;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_be = '0; req_wdata = '0; ref_req = 1'b0;
    last_addr = '0; last_wr = 1'b0; last_be = '0;
    repeat (3) @(negedge clk);
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid} === 7'b1111100,
          "R1", "strobes in reset", {25'h0, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid},
          32'h7C);
    rst_n = 1'b1;
    @(negedge clk);
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe} === 6'b111110 && req_ready === 1'b1,
          "R1", "state after reset", {26'h0, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, req_ready}, 32'h3F);

    // Page hits in row 0x05: word write, lower-byte, upper-byte writes, reads
    issue(1'b1, 16'h0510, 2'b11, 16'h1234);
    issue(1'b1, 16'h0511, 2'b11, 16'hAAAA);
    issue(1'b1, 16'h0511, 2'b01, 16'h55CD);   // R3 lower byte only
    issue(1'b1, 16'h0512, 2'b11, 16'h7777);
    issue(1'b1, 16'h0512, 2'b10, 16'hE199);   // R3 upper byte only
    issue(1'b0, 16'h0510, 2'b11, 16'h0);
    issue(1'b0, 16'h0511, 2'b11, 16'h0);
    issue(1'b0, 16'h0512, 2'b11, 16'h0);
    issue(1'b1, 16'h0513, 2'b11, 16'hBEEF);   // R10 write right after read
    issue(1'b0, 16'h0513, 2'b11, 16'h0);
    drain();
    check(ras_falls == 1, "R5", "single activation for page hits", ras_falls, 1);

    // Row miss
    issue(1'b0, 16'h0900, 2'b11, 16'h0);
    issue(1'b1, 16'h0901, 2'b11, 16'hC0DE);
    drain();
    check(ras_falls == 2, "R6", "miss reactivates row", ras_falls, 2);

    // Refresh request while row 0x09 is open
    @(negedge clk);
    ref_req = 1'b1;
    repeat (T_RP + 6) @(negedge clk);
    check(dram_ras_n === 1'b1 && ref_gnt === 1'b1, "R7", "row closed and granted",
          {30'h0, dram_ras_n, ref_gnt}, 32'h3);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0901; req_be = 2'b11;
    falls0 = ras_falls;
    repeat (5) begin
      @(negedge clk);
      #1;
      check(req_ready === 1'b0, "R7", "no accept during refresh", {31'h0, req_ready}, 32'h0);
    end
    check(ras_falls == falls0, "R7", "no activation during refresh", ras_falls, falls0);
    req_valid = 1'b0;
    ref_req = 1'b0;
    issue(1'b0, 16'h0901, 2'b11, 16'h0);
    drain();
    check(ras_falls == falls0 + 1, "R7", "reactivation after refresh", ras_falls, falls0 + 1);

    // Mixed traffic over three rows
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] row;
      logic [1:0] be;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0:    row = 8'h05;
        2'd1:    row = 8'h09;
        default: row = 8'h3C;
      endcase
      be = (lfsr[5:4] == 2'b00) ? 2'b11 : lfsr[5:4];
      issue(lfsr[2], {row, 4'h0, lfsr[9:6]}, be, {lfsr[7:0], lfsr[15:8]});
    end
    drain();
    check(exp_q.size() == 0, "R11", "all reads returned", exp_q.size(), 0);
    finish_run();
  end

endmodule